// File: doc/BRIEF.md
# Complementary Dead-Time Generator

The block turns a single PWM waveform into a pair of complementary outputs that are never high together. The true output follows the waveform and the complementary output follows its inverse. The rising edge of each output is held back by its own programmable number of delay units, and the falling edge passes straight through. Both outputs are therefore low for a dead band around every transition of the waveform.

The delay unit is the timer clock divided by 1, 2, 4 or 8. Each output channel holds its own small prescaler, which restarts when the channel's level goes low. The delay is therefore an exact number of clocks: the field value times the division factor, counted from the clock edge after the waveform change. One control bit inverts both outputs after the dead-band logic, for drivers whose switches are active low.

Top module: `dtg_top`

## Requirements
- R1: While rst_ni is low, both delay counters are held clear, so an output whose delay field is non-zero is low.
- R2: The true output rises exactly D*N clock edges after pwm_i rises, where D is dt_val_i[7:4] and N is the division factor. It then stays high while pwm_i stays high.
- R3: The complementary output rises exactly L*N clock edges after pwm_i falls, where L is dt_val_i[3:0].
- R4: dt_div_i selects N: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8.
- R5: Falling edges are not delayed. The true output is low in the same cycle that pwm_i is low, and the complementary output is low in the same cycle that pwm_i is high.
- R6: With invert_i low, true_o and comp_o are never high at the same time.
- R7: If pwm_i changes again before a pending delay has run out, that output stays low, and the next edge starts a full new delay.
- R8: A delay field of 0 passes the rising edge through in the same cycle, with no added clock.
- R9: With invert_i high, both outputs are the bitwise inverse of the values they would have with invert_i low.
- R10: The longest delay, field 15 with code 3, gives 120 clocks of dead band, and the output then rises on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM waveform to be split |
| dt_val_i | input | 8 | Dead time: [7:4] for the true output, [3:0] for the complementary output |
| dt_div_i | input | 2 | Delay unit prescale code (divide by 1, 2, 4 or 8) |
| invert_i | input | 1 | Inverts both outputs when high |
| true_o | output | 1 | True output with delayed rising edge |
| comp_o | output | 1 | Complementary output with delayed rising edge |

## Verification
The waveform is driven with long high and low phases under different upper and lower fields. This separates the two channels' delays from each other and from the prescale code, because every division factor gives its own expected rise cycle. Pulses shorter than the programmed delay show whether a pending edge is cancelled and later restarted from zero, as opposed to resuming where it stopped. Zero fields, the maximum field with the largest divider, and a phase with inversion enabled cover the pass-through, the counter saturation and the output polarity.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned DIV_W   = 2;
  localparam int unsigned NUM_CH  = 2;

  typedef enum logic [0:0] {
    CH_TRUE = 1'b0,
    CH_COMP = 1'b1
  } dtg_ch_e;
endpackage

// File: rtl/dtg_prescaler.sv
module dtg_prescaler #(
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] code_i,
  output logic             tick_o
);
  localparam int unsigned PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask   = (PRE_W'(1) << code_i) - PRE_W'(1);
  assign tick_o = run_i && (pre_q == mask);

  // phase restarts whenever the channel is idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (!run_i)  pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else              pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/dtg_edge_delay.sv
module dtg_edge_delay #(
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned DIV_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               level_i,
  input  logic [FIELD_W-1:0] delay_i,
  input  logic [DIV_W-1:0]   code_i,
  output logic               out_o
);
  localparam logic [FIELD_W-1:0] CNT_MAX = '1;

  logic               tick;
  logic [FIELD_W-1:0] cnt_q;

  dtg_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (level_i),
    .code_i (code_i),
    .tick_o (tick)
  );

  // saturating unit counter, cleared while level is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!level_i)                   cnt_q <= '0;
    else if (tick && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + FIELD_W'(1);
  end

  // falling edge is immediate, rising edge waits for the count
  assign out_o = level_i && (cnt_q >= delay_i);
endmodule

// File: rtl/dtg_top.sv
module dtg_top
  import dtg_pkg::*;
#(
  parameter int unsigned FW = FIELD_W,
  parameter int unsigned DW = DIV_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwm_i,
  input  logic [2*FW-1:0] dt_val_i,
  input  logic [DW-1:0]   dt_div_i,
  input  logic            invert_i,
  output logic            true_o,
  output logic            comp_o
);
  logic [NUM_CH-1:0] raw;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int unsigned LSB = (NUM_CH - 1 - g) * FW;
    logic level;
    assign level = (g == int'(CH_TRUE)) ? pwm_i : ~pwm_i;

    dtg_edge_delay #(.FIELD_W(FW), .DIV_W(DW)) u_dly (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (level),
      .delay_i (dt_val_i[LSB +: FW]),
      .code_i  (dt_div_i),
      .out_o   (raw[g])
    );
  end

  assign true_o = raw[CH_TRUE] ^ invert_i;
  assign comp_o = raw[CH_COMP] ^ invert_i;
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
  parameter int unsigned FW = 4,
  parameter int unsigned DW = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pwm_i,
  input logic [2*FW-1:0] dt_val_i,
  input logic [DW-1:0]   dt_div_i,
  input logic            invert_i,
  input logic            true_o,
  input logic            comp_o
);
  assert_no_overlap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !invert_i |-> !(true_o && comp_o));

  assert_true_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!invert_i && !pwm_i) |-> !true_o);

  assert_comp_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!invert_i && pwm_i) |-> !comp_o);

  assert_delayed_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!invert_i && $stable(invert_i) && (dt_val_i[2*FW-1:FW] != '0) && $rose(true_o))
      |-> $past(pwm_i));

  assert_pass_through_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!invert_i && pwm_i && (dt_val_i[2*FW-1:FW] == '0)) |-> true_o);

  assert_invert_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (invert_i && !pwm_i) |-> true_o);
endmodule

bind dtg_top dtg_checker #(.FW(FW), .DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pwm_i    (pwm_i),
  .dt_val_i (dt_val_i),
  .dt_div_i (dt_div_i),
  .invert_i (invert_i),
  .true_o   (true_o),
  .comp_o   (comp_o)
);

// File: tb/dtg_top_tb.sv
module dtg_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_SAT    = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm = 1'b0;
  logic [7:0] dt_val = 8'h35;
  logic [1:0] dt_div = 2'd0;
  logic       inv = 1'b0;
  logic       true_o, comp_o;

  int checks = 0;
  int errors = 0;
  int hi_run = 0;
  int lo_run = 0;

  typedef struct {
    logic  exp_t;
    logic  exp_c;
    logic  inv;
    string tag;
  } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dtg_top u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .pwm_i    (pwm),
    .dt_val_i (dt_val),
    .dt_div_i (dt_div),
    .invert_i (inv),
    .true_o   (true_o),
    .comp_o   (comp_o)
  );

  // driver: one item per cycle, expected values from edge counts since the last change
  task automatic step(input logic p, input int n, input logic [7:0] dt,
                      input logic [1:0] dv, input logic iv, input string tag);
    item_t it;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      if (!rst_n) begin
        hi_run = 0; lo_run = 0;
      end else if (pwm) begin
        hi_run = (hi_run < RUN_SAT) ? hi_run + 1 : hi_run; lo_run = 0;
      end else begin
        lo_run = (lo_run < RUN_SAT) ? lo_run + 1 : lo_run; hi_run = 0;
      end
      #1;
      pwm = p; dt_val = dt; dt_div = dv; inv = iv;
      it.exp_t = (p  && (hi_run >= (int'(dt[7:4]) << dv))) ^ iv;
      it.exp_c = (!p && (lo_run >= (int'(dt[3:0]) << dv))) ^ iv;
      it.inv   = iv;
      it.tag   = tag;
      q.push_back(it);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (true_o !== it.exp_t) begin
        errors++;
        $display("FAIL %s true_o actual %b expected %b at %0t", it.tag, true_o, it.exp_t, $time);
      end
      checks++;
      if (comp_o !== it.exp_c) begin
        errors++;
        $display("FAIL %s comp_o actual %b expected %b at %0t", it.tag, comp_o, it.exp_c, $time);
      end
      if (!it.inv) begin
        checks++;
        if (true_o && comp_o) begin
          errors++;
          $display("FAIL R6 overlap actual %b%b expected not 11 at %0t", true_o, comp_o, $time);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset holds counters clear
    step(1'b0, 3, 8'h35, 2'd0, 1'b0, "R1");
    rst_n = 1'b1;
    // R3: comp rises 5 edges after release, R2 and R5 on the high phase
    step(1'b0, 8,  8'h35, 2'd0, 1'b0, "R3");
    step(1'b1, 10, 8'h35, 2'd0, 1'b0, "R2 R5");
    step(1'b0, 10, 8'h35, 2'd0, 1'b0, "R3 R5");
    // R4: divide by 2 then by 4
    step(1'b1, 12, 8'h35, 2'd1, 1'b0, "R4 R2");
    step(1'b0, 14, 8'h35, 2'd1, 1'b0, "R4 R3");
    step(1'b1, 12, 8'h21, 2'd2, 1'b0, "R4 R2");
    step(1'b0, 8,  8'h21, 2'd2, 1'b0, "R4 R3");
    // R7: short pulses cancel the pending edge, then a full restart
    step(1'b1, 2, 8'h44, 2'd0, 1'b0, "R7");
    step(1'b0, 2, 8'h44, 2'd0, 1'b0, "R7");
    step(1'b1, 3, 8'h44, 2'd0, 1'b0, "R7");
    step(1'b0, 1, 8'h44, 2'd0, 1'b0, "R7");
    step(1'b1, 8, 8'h44, 2'd0, 1'b0, "R7");
    // R8: zero fields pass through
    step(1'b0, 3, 8'h00, 2'd0, 1'b0, "R8");
    step(1'b1, 3, 8'h00, 2'd0, 1'b0, "R8");
    step(1'b0, 3, 8'h00, 2'd3, 1'b0, "R8");
    // R9: inversion of both outputs
    step(1'b1, 6, 8'h23, 2'd0, 1'b1, "R9");
    step(1'b0, 6, 8'h23, 2'd0, 1'b1, "R9");
    // R10: maximum field with divide by 8
    step(1'b1, 125, 8'hFF, 2'd3, 1'b0, "R10");
    step(1'b0, 125, 8'hFF, 2'd3, 1'b0, "R10");
    step(1'b1, 4,   8'h11, 2'd0, 1'b0, "R2");
    @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule